// File: doc/BRIEF.md
# Dual Four-Mode Gated Timer/Counter

This block holds two 16-bit timer/counters, each kept as a low byte and a high byte, with one shared configuration register and one shared control register. Each timer has a 4-bit configuration field: a gate bit, a source select and a two-bit mode. A timer steps on a prescaled internal tick or on falling edges of its own event pin. It can also be gated so that it runs only while its gate pin is high.

Four modes are provided: a 13-bit counter (5-bit prescaler in the low byte feeding the high byte), a plain 16-bit counter, an 8-bit counter that reloads from the high byte on wrap, and a split mode. In split mode timer 0 becomes two independent 8-bit counters. Its high half takes timer 1's run bit and sets timer 1's overflow flag, while timer 1 placed in split mode stands still. Software reaches all six registers through a small byte-wide register port. The two overflow flags are also driven out as pins.

Top module: `tmr_pair`

## Requirements
- R1: After reset every register reads 0 (configuration, control, all four count bytes) and both `ovf_flag` bits are 0.
- R2: Register addresses: 0 configuration (bits 7:4 timer 1, bits 3:0 timer 0, each nibble gate/source/mode-high/mode-low from high bit to low bit), 1 control (bit 0 run0, bit 1 run1, bit 2 flag0, bit 3 flag1, bits 7:4 read 0), 2/3 timer 0 low/high, 4/5 timer 1 low/high. Addresses 6 and 7 read 0 and writes there change nothing.
- R3: With its gate bit 0 a timer steps whenever its run bit is 1. With its gate bit 1 it steps only while its run bit is 1 and its gate pin is high.
- R4: With source bit 0 a timer steps once per cycle in which `tick` is high. With source bit 1 it ignores `tick` and steps once per falling edge of its event pin, found by comparing two successive registered samples. Rising edges and steady levels never step it.
- R5: Mode 0 (mode bits 00): bits 4:0 of the low byte form a divide-by-32 prescaler. When they wrap from 31 to 0 the high byte steps. Bits 7:5 of the low byte never change. The overflow flag sets when the high byte wraps from 0xFF.
- R6: Mode 1 (01): {high, low} is a 16-bit counter whose wrap from 0xFFFF sets the overflow flag.
- R7: Mode 2 (10): the low byte counts. On a step from 0xFF it loads the high byte's value and sets the overflow flag. The high byte is left unchanged.
- R8: Mode 3 (11) on timer 0: the low byte is an 8-bit counter under timer 0's run, gate and source, and its wrap sets flag0. The high byte steps on `tick` while run1 is 1, and its wrap sets flag1.
- R9: Timer 1 in mode 3 holds both its bytes whatever its run bit and inputs are.
- R10: While timer 0 is in mode 3, timer 1 keeps counting in its own mode, but its wrap sets no flag.
- R11: Overflow flags are sticky: once set they stay 1 until software writes the control register. `ovf_flag[i]` always equals control bit 2+i.
- R12: A register write wins over hardware in the same cycle. A write to either byte of a timer cancels that timer's step and wrap for that cycle, and the unwritten byte holds. A control write sets the flags to the written value even if an overflow occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled internal count enable |
| evt_pin | input | 2 | External event inputs, one per timer |
| gate_pin | input | 2 | Hardware gate inputs, one per timer |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ovf_flag | output | 2 | Overflow flags of timer 0 and timer 1 |

## Verification
The bench preloads each timer just below a wrap point in every mode. A wrong 13-bit prescaler would disturb the low byte's upper three bits or carry at the wrong count. A wrong reload would restart from zero instead of the high byte. It drives the split mode with each run bit alone, which catches a high half that follows the wrong run bit or raises the wrong flag. It also catches a timer 1 that still raises its flag while timer 0 is split. Writes are placed in the same cycle as a step or an overflow, so a design that lets the increment or the flag set win would leave a visibly different byte or flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W  = 8;
    localparam int PRE_W   = 5;
    localparam int ADDR_W  = 3;
    localparam int N_TMR   = 2;
    localparam int CFG_W   = 4;
    localparam int CTL_W   = 2 * N_TMR;
    localparam int RUN_LSB = 0;
    localparam int OVF_LSB = N_TMR;

    localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTL  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT0 = 3'd2;

    typedef enum logic [1:0] {
        MODE_13    = 2'b00,
        MODE_16    = 2'b01,
        MODE_8RL   = 2'b10,
        MODE_SPLIT = 2'b11
    } tmode_e;

    typedef struct packed {
        logic   gate;
        logic   evt;
        tmode_e mode;
    } tcfg_s;

    function automatic logic [ADDR_W-1:0] lo_addr(input int idx);
        return A_CNT0 + ADDR_W'(2 * idx);
    endfunction

    function automatic logic [ADDR_W-1:0] hi_addr(input int idx);
        return A_CNT0 + ADDR_W'(2 * idx + 1);
    endfunction

endpackage

// File: rtl/tmr_edge.sv
module tmr_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin,
    output logic [N-1:0] fall
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        logic smp_now, smp_old;
        always_ff @(posedge clk) begin
            if (rst) begin
                smp_now <= 1'b0;
                smp_old <= 1'b0;
            end else begin
                smp_now <= pin[g];
                smp_old <= smp_now;
            end
        end
        assign fall[g] = smp_old & ~smp_now;
    end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter bit CAN_SPLIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  tcfg_s             cfg,
    input  logic              run,
    input  logic              run_alt,
    input  logic              gate_pin,
    input  logic              evt_fall,
    input  logic              tick,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] hi,
    output logic              wrap_a,
    output logic              wrap_b
);
    localparam int WIDE = 2 * BYTE_W;

    logic              en, step, step_alt;
    logic [BYTE_W-1:0] lo_n, hi_n;
    logic [WIDE-1:0]   sum;

    always_comb begin
        en       = run & (~cfg.gate | gate_pin);
        step     = en & (cfg.evt ? evt_fall : tick);
        step_alt = run_alt & tick;
        sum      = {hi, lo} + WIDE'(1);
        lo_n     = lo;
        hi_n     = hi;
        wrap_a   = 1'b0;
        wrap_b   = 1'b0;
        case (cfg.mode)
            MODE_13: begin
                if (step) begin
                    if (&lo[PRE_W-1:0]) begin
                        lo_n[PRE_W-1:0] = '0;
                        hi_n            = hi + 1'b1;
                        wrap_a          = &hi;
                    end else begin
                        lo_n[PRE_W-1:0] = lo[PRE_W-1:0] + 1'b1;
                    end
                end
            end
            MODE_16: begin
                if (step) begin
                    {hi_n, lo_n} = sum;
                    wrap_a       = &{hi, lo};
                end
            end
            MODE_8RL: begin
                if (step) begin
                    if (&lo) begin
                        lo_n   = hi;
                        wrap_a = 1'b1;
                    end else begin
                        lo_n = lo + 1'b1;
                    end
                end
            end
            default: begin
                if (CAN_SPLIT) begin
                    if (step) begin
                        lo_n   = lo + 1'b1;
                        wrap_a = &lo;
                    end
                    if (step_alt) begin
                        hi_n   = hi + 1'b1;
                        wrap_b = &hi;
                    end
                end
            end
        endcase
        if (we_lo | we_hi) begin
            wrap_a = 1'b0;
            wrap_b = 1'b0;
            lo_n   = we_lo ? wdata : lo;
            hi_n   = we_hi ? wdata : hi;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo <= '0;
            hi <= '0;
        end else begin
            lo <= lo_n;
            hi <= hi_n;
        end
    end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [1:0]        evt_pin,
    input  logic [1:0]        gate_pin,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [1:0]        ovf_flag
);
    tcfg_s [N_TMR-1:0]            cfg_q;
    logic  [CTL_W-1:0]            ctl_q;
    logic  [N_TMR-1:0]            evt_fall;
    logic  [N_TMR-1:0]            wrap_a, wrap_b;
    logic  [N_TMR-1:0][BYTE_W-1:0] cnt_lo, cnt_hi;
    logic                         split;
    logic  [N_TMR-1:0]            flag_set;

    tmr_edge #(.N(N_TMR)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .pin  (evt_pin),
        .fall (evt_fall)
    );

    for (genvar g = 0; g < N_TMR; g++) begin : g_unit
        logic we_lo, we_hi;
        assign we_lo = reg_we && (reg_addr == lo_addr(g));
        assign we_hi = reg_we && (reg_addr == hi_addr(g));
        tmr_unit #(.CAN_SPLIT(g == 0)) u_unit (
            .clk      (clk),
            .rst      (rst),
            .cfg      (cfg_q[g]),
            .run      (ctl_q[RUN_LSB + g]),
            .run_alt  (ctl_q[RUN_LSB + 1]),
            .gate_pin (gate_pin[g]),
            .evt_fall (evt_fall[g]),
            .tick     (tick),
            .we_lo    (we_lo),
            .we_hi    (we_hi),
            .wdata    (reg_wdata),
            .lo       (cnt_lo[g]),
            .hi       (cnt_hi[g]),
            .wrap_a   (wrap_a[g]),
            .wrap_b   (wrap_b[g])
        );
    end

    assign split       = (cfg_q[0].mode == MODE_SPLIT);
    assign flag_set[0] = wrap_a[0];
    assign flag_set[1] = split ? wrap_b[0] : (wrap_a[1] | wrap_b[1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            ctl_q <= '0;
        end else begin
            if (reg_we && reg_addr == A_CFG)
                cfg_q <= reg_wdata;
            if (reg_we && reg_addr == A_CTL)
                ctl_q <= reg_wdata[CTL_W-1:0];
            else
                ctl_q[OVF_LSB +: N_TMR] <= ctl_q[OVF_LSB +: N_TMR] | flag_set;
        end
    end

    always_comb begin
        case (reg_addr)
            A_CFG:      reg_rdata = cfg_q;
            A_CTL:      reg_rdata = {{(BYTE_W-CTL_W){1'b0}}, ctl_q};
            lo_addr(0): reg_rdata = cnt_lo[0];
            hi_addr(0): reg_rdata = cnt_hi[0];
            lo_addr(1): reg_rdata = cnt_lo[1];
            hi_addr(1): reg_rdata = cnt_hi[1];
            default:    reg_rdata = '0;
        endcase
    end

    assign ovf_flag = ctl_q[OVF_LSB +: N_TMR];
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] cfg,
    input logic [3:0] ctl,
    input logic [7:0] lo0,
    input logic [7:0] hi0,
    input logic [7:0] lo1,
    input logic [7:0] hi1,
    input logic       reg_we,
    input logic [2:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic [1:0] gate_pin
);
    logic wr_ctl, wr_t0, wr_t1;
    assign wr_ctl = reg_we && reg_addr == 3'd1;
    assign wr_t0  = reg_we && (reg_addr == 3'd2 || reg_addr == 3'd3);
    assign wr_t1  = reg_we && (reg_addr == 3'd4 || reg_addr == 3'd5);

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg == 8'd0 && ctl == 4'd0 && lo0 == 8'd0 && hi0 == 8'd0
                        && lo1 == 8'd0 && hi1 == 8'd0));

    a_r12_write_wins: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 3'd2) |=> lo0 == $past(reg_wdata));

    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (ctl[2] && !wr_ctl) |=> ctl[2]);

    a_r9_t1_halt: assert property (@(posedge clk) disable iff (rst)
        (cfg[5:4] == 2'b11 && !wr_t1) |=> ($stable(lo1) && $stable(hi1)));

    a_r3_gate_block: assert property (@(posedge clk) disable iff (rst)
        (cfg[3] && !gate_pin[0] && cfg[1:0] != 2'b11 && !wr_t0)
        |=> ($stable(lo0) && $stable(hi0)));

    a_r10_split_no_flag1: assert property (@(posedge clk) disable iff (rst)
        (cfg[1:0] == 2'b11 && !ctl[1] && !ctl[3] && !wr_ctl) |=> !ctl[3]);
endmodule

bind tmr_pair tmr_pair_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg_q),
    .ctl       (ctl_q),
    .lo0       (cnt_lo[0]),
    .hi0       (cnt_hi[0]),
    .lo1       (cnt_lo[1]),
    .hi1       (cnt_hi[1]),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .gate_pin  (gate_pin)
);

// File: tb/test_tmr_pair.sv
module test_tmr_pair;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] evt_pin = 2'b11;
    logic [1:0] gate_pin = 2'b00;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [1:0] ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_pair i_tmr_pair (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .evt_pin   (evt_pin),
        .gate_pin  (gate_pin),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ovf_flag  (ovf_flag)
    );

    typedef struct packed {
        logic       sel;
        logic [7:0] mode;
        logic [7:0] lo;
        logic [7:0] hi;
        logic [3:0] run;
        logic [7:0] n;
        logic [7:0] exp_lo;
        logic [7:0] exp_hi;
        logic [3:0] exp_ctl;
        logic [7:0] req;
    } vec_s;

    localparam int NV = 10;
    localparam vec_s VEC [NV] = '{
        '{1'b0, 8'h01, 8'hFE, 8'h00, 4'h1, 8'd3, 8'h01, 8'h01, 4'h1, 8'd6},  // R6 carry
        '{1'b0, 8'h01, 8'hFE, 8'hFF, 4'h1, 8'd3, 8'h01, 8'h00, 4'h5, 8'd6},  // R6 wrap
        '{1'b0, 8'h00, 8'hFE, 8'h00, 4'h1, 8'd3, 8'hE1, 8'h01, 4'h1, 8'd5},  // R5 prescale
        '{1'b0, 8'h00, 8'hBF, 8'hFF, 4'h1, 8'd1, 8'hA0, 8'h00, 4'h5, 8'd5},  // R5 wrap
        '{1'b0, 8'h02, 8'hFE, 8'h80, 4'h1, 8'd4, 8'h82, 8'h80, 4'h5, 8'd7},  // R7 reload
        '{1'b1, 8'h10, 8'hFF, 8'h12, 4'h2, 8'd2, 8'h01, 8'h13, 4'h2, 8'd6},  // R6 timer 1
        '{1'b1, 8'h20, 8'hFF, 8'hF0, 4'h2, 8'd3, 8'hF2, 8'hF0, 4'hA, 8'd7},  // R7 timer 1
        '{1'b0, 8'h03, 8'hFE, 8'hFD, 4'h3, 8'd3, 8'h01, 8'h00, 4'hF, 8'd8},  // R8 both halves
        '{1'b0, 8'h03, 8'h10, 8'h20, 4'h1, 8'd3, 8'h13, 8'h20, 4'h1, 8'd8},  // R8 run0 only
        '{1'b0, 8'h03, 8'h10, 8'h20, 4'h2, 8'd3, 8'h10, 8'h23, 4'h2, 8'd8}   // R8 run1 only
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic clear_all(input logic [7:0] mode);
        wr(3'd1, 8'h00);
        wr(3'd0, mode);
        for (int a = 2; a < 6; a++) wr(3'(a), 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R2 unused addresses read 0
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 reset register", d, 8'h00);
        end
        check("R1 reset flags", {6'd0, ovf_flag}, 8'h00);

        // R2 register map and unused address writes
        wr(3'd0, 8'hA5); rd(3'd0, d); check("R2 config readback", d, 8'hA5);
        wr(3'd1, 8'hF0); rd(3'd1, d); check("R2 control upper bits read 0", d, 8'h00);
        wr(3'd6, 8'h77); rd(3'd6, d); check("R2 address 6 reads 0", d, 8'h00);
        rd(3'd0, d); check("R2 address 6 write changes nothing", d, 8'hA5);

        // Vector walk: R5 R6 R7 R8 R11
        for (int i = 0; i < NV; i++) begin
            clear_all(VEC[i].mode);
            wr(VEC[i].sel ? 3'd4 : 3'd2, VEC[i].lo);
            wr(VEC[i].sel ? 3'd5 : 3'd3, VEC[i].hi);
            wr(3'd1, {4'd0, VEC[i].run});
            ticks(int'(VEC[i].n));
            rd(VEC[i].sel ? 3'd4 : 3'd2, d);
            check($sformatf("R%0d vec %0d low", VEC[i].req, i), d, VEC[i].exp_lo);
            rd(VEC[i].sel ? 3'd5 : 3'd3, d);
            check($sformatf("R%0d vec %0d high", VEC[i].req, i), d, VEC[i].exp_hi);
            rd(3'd1, d);
            check($sformatf("R%0d vec %0d control", VEC[i].req, i), d, {4'd0, VEC[i].exp_ctl});
            check($sformatf("R11 vec %0d flag pins", i), {6'd0, ovf_flag}, {6'd0, VEC[i].exp_ctl[3:2]});
        end

        // R3 gating
        clear_all(8'h09);
        wr(3'd1, 8'h01);
        gate_pin = 2'b00;
        ticks(3);
        rd(3'd2, d); check("R3 gate low blocks", d, 8'h00);
        gate_pin = 2'b01;
        ticks(3);
        rd(3'd2, d); check("R3 gate high runs", d, 8'h03);
        gate_pin = 2'b00;

        // R4 event counting on falling edges, tick ignored
        clear_all(8'h50);
        wr(3'd1, 8'h02);
        @(negedge clk); tick = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); evt_pin[1] = 1'b0;
            repeat (3) @(negedge clk);
            evt_pin[1] = 1'b1;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        tick = 1'b0;
        rd(3'd4, d); check("R4 falling edges counted", d, 8'h04);
        rd(3'd5, d); check("R4 high byte", d, 8'h00);

        // R9 timer 1 in mode 3 holds
        clear_all(8'h30);
        wr(3'd4, 8'h34); wr(3'd5, 8'h12);
        wr(3'd1, 8'h02);
        ticks(5);
        rd(3'd4, d); check("R9 timer1 low held", d, 8'h34);
        rd(3'd5, d); check("R9 timer1 high held", d, 8'h12);

        // R10 timer 1 wrap while split sets no flag
        clear_all(8'h03);
        wr(3'd4, 8'h1F); wr(3'd5, 8'hFF);
        wr(3'd1, 8'h02);
        ticks(1);
        rd(3'd4, d); check("R10 timer1 counted", d, 8'h00);
        rd(3'd5, d); check("R10 timer1 high wrapped", d, 8'h00);
        rd(3'd3, d); check("R10 timer0 high on run1", d, 8'h01);
        rd(3'd1, d); check("R10 no flag1", d, 8'h02);

        // R12 count-byte write beats step
        clear_all(8'h01);
        wr(3'd2, 8'hFF);
        wr(3'd1, 8'h01);
        @(negedge clk);
        tick = 1'b1; reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h50;
        @(negedge clk);
        tick = 1'b0; reg_we = 1'b0;
        rd(3'd2, d); check("R12 written low wins", d, 8'h50);
        rd(3'd3, d); check("R12 high held", d, 8'h00);

        // R12 control write beats overflow flag
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        @(negedge clk);
        tick = 1'b1; reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h01;
        @(negedge clk);
        tick = 1'b0; reg_we = 1'b0;
        rd(3'd2, d); check("R12 counter still stepped", d, 8'h00);
        rd(3'd1, d); check("R12 control write wins flag", d, 8'h01);

        // R11 sticky flag and clearing
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        ticks(1);
        ticks(2);
        rd(3'd1, d); check("R11 flag stays set", d, 8'h05);
        rd(3'd2, d); check("R11 counter continues", d, 8'h02);
        wr(3'd1, 8'h01);
        rd(3'd1, d); check("R11 flag cleared by write", d, 8'h01);
        check("R11 flag pin cleared", {6'd0, ovf_flag}, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule